// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge and Vector Generator

This block pairs two eight-line interrupt controllers in a cascade and answers the processor's interrupt acknowledge. It holds the pending and in-service state of both controllers. It captures the external request lines and resolves the winning line of each controller by rotating priority. It drives one combined interrupt line toward the processor. Whenever the secondary controller has a request that can win, that request shows up as a pending request on input 2 of the primary controller.

When the processor pulses the acknowledge strobe, the block marks the winners as in service. It clears their pending bits where the line is edge triggered. One clock later it presents an 8-bit vector together with a one-cycle valid strobe. The upper five vector bits come from the programmed base of the controller that supplied the line. The lower three bits hold the line number, or 7 when no line could be found. Trigger mode, masks, bases and the automatic end-of-interrupt options arrive as static configuration inputs, because register programming belongs to another block.

Top module: `icv_ack_vec`

## Requirements
- R1: After reset, `int_o` and `vec_vld_o` are 0, no line is pending or in service, and the rotation base of both controllers is 0.
- R2: An edge-triggered line (its bit in `lvl_mode_i` is 0) becomes pending on a 0-to-1 transition and stays pending after the line falls. A level-triggered line (bit = 1) is pending exactly while it is high.
- R3: A controller's winner is the pending, unmasked line with the lowest rotated priority, (line - base) mod 8. Its request is presented only when no in-service line has an equal or lower rotated priority. Masked lines (`mask_i` bit = 1) are never presented.
- R4: On acknowledge outside automatic end-of-interrupt mode, the winning line's in-service bit is set. This blocks lines of equal or lower priority until reset.
- R5: On acknowledge, the winner's pending bit is cleared only for an edge-triggered line. A level-triggered line that is still high stays pending.
- R6: Master line 2 is fed by the slave: each cycle the slave has a winner, master line 2 is set pending, except when master bit 2 of `lvl_mode_i` is 1. When the master winner is line 2, the slave winner is acknowledged too, and the vector is {`slv_base_i`, slave line}.
- R7: If the master winner is line 2 but the slave has no winner, the vector is {`slv_base_i`, 3'd7}, and no slave state changes.
- R8: If the master has no winner at acknowledge, the vector is {`mst_base_i`, 3'd7}, and no in-service bit is set.
- R9: In automatic end-of-interrupt mode (`aeoi_i` bit 0 for master, bit 1 for slave), acknowledge leaves the in-service bits unchanged. If the matching `rot_aeoi_i` bit is also 1, the rotation base becomes (line + 1) mod 8.
- R10: `vec_vld_o` is high for exactly the cycle after an acknowledge cycle, and `vec_o` holds the vector in that cycle. `int_o` is low in that cycle. At all other times, `int_o` equals the master's "winner present" status of the previous cycle.
- R11: With master bit 2 of `lvl_mode_i` set to 1, a slave request never makes master line 2 pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slv_irq_i | input | 8 | Slave request lines 0..7 |
| mst_irq_i | input | 7 | Master request lines; bits 1:0 are lines 1:0, bits 6:2 are lines 7:3 (line 2 is the cascade) |
| lvl_mode_i | input | 16 | Trigger mode per line, 1 = level; bits 7:0 master, 15:8 slave |
| mask_i | input | 16 | Mask per line, 1 = masked; bits 7:0 master, 15:8 slave |
| mst_base_i | input | 5 | Master vector base (upper vector bits) |
| slv_base_i | input | 5 | Slave vector base (upper vector bits) |
| aeoi_i | input | 2 | Automatic end-of-interrupt enable; bit 0 master, bit 1 slave |
| rot_aeoi_i | input | 2 | Rotate on automatic end-of-interrupt; bit 0 master, bit 1 slave |
| inta_i | input | 1 | Acknowledge strobe, one cycle per acknowledge |
| vec_o | output | 8 | Vector byte |
| vec_vld_o | output | 1 | Vector valid strobe |
| int_o | output | 1 | Combined interrupt request to the processor |

## Verification
Pending and in-service state is only visible through `int_o` and the vectors that later acknowledges return. A stale in-service bit therefore shows up a few cycles after the next request, as an `int_o` that stays low. A pending bit that was wrongly kept or cleared shows up as a wrong vector, or as a missing vector, on the following acknowledge. A wrong rotation base shows up as the second of two simultaneous requests coming out in the wrong order. A fault in the cascade path shows up as a master-based vector where a slave-based one was due, or as a spurious 7 in the low bits one cycle after the acknowledge.

// File: rtl/icv_pkg.sv
package icv_pkg;
    localparam int ICV_LINES     = 8;
    localparam int ICV_CASC_LINE = 2;
    localparam int ICV_VEC_W     = 8;

    // Where the vector returned by an acknowledge comes from
    typedef enum logic [1:0] {
        SRC_MST_LINE = 2'd0,
        SRC_MST_SPUR = 2'd1,
        SRC_SLV_LINE = 2'd2,
        SRC_SLV_SPUR = 2'd3
    } vec_src_t;
endpackage

// File: rtl/icv_prio.sv
// Rotating-priority resolver for one controller (combinational)
module icv_prio #(
    parameter int LINES = icv_pkg::ICV_LINES,
    localparam int LW = $clog2(LINES)
) (
    input  logic [LINES-1:0] req_i,
    input  logic [LINES-1:0] mask_i,
    input  logic [LINES-1:0] isr_i,
    input  logic [LW-1:0]    base_i,
    output logic             hit_o,
    output logic [LW-1:0]    line_o
);
    logic [LW-1:0] idx;
    logic [LW-1:0] p_req, p_isr;
    logic          has_req, has_isr;

    always_comb begin
        idx     = '0;
        p_req   = '0;
        p_isr   = '0;
        has_req = 1'b0;
        has_isr = 1'b0;
        // scan downward so the lowest rotated priority is kept last
        for (int p = LINES - 1; p >= 0; p--) begin
            idx = LW'(p) + base_i;
            if (req_i[idx] && !mask_i[idx]) begin
                has_req = 1'b1;
                p_req   = LW'(p);
            end
            if (isr_i[idx]) begin
                has_isr = 1'b1;
                p_isr   = LW'(p);
            end
        end
        hit_o  = has_req && (!has_isr || (p_req < p_isr));
        line_o = p_req + base_i;
    end
endmodule

// File: rtl/icv_unit.sv
// Request capture, in-service tracking and rotation base of one controller
module icv_unit #(
    parameter int LINES     = icv_pkg::ICV_LINES,
    parameter int HAS_CASC  = 0,
    parameter int CASC_LINE = icv_pkg::ICV_CASC_LINE,
    localparam int LW = $clog2(LINES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LINES-1:0] raw_i,
    input  logic [LINES-1:0] lvl_i,
    input  logic [LINES-1:0] mask_i,
    input  logic             aeoi_i,
    input  logic             rot_i,
    input  logic             take_i,
    input  logic [LW-1:0]    take_line_i,
    output logic             hit_o,
    output logic [LW-1:0]    line_o
);
    typedef struct packed {
        logic [LINES-1:0] irr;
        logic [LINES-1:0] isr;
        logic [LINES-1:0] last;
        logic [LW-1:0]    base;
    } unit_state_t;

    unit_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.last = raw_i;
        for (int l = 0; l < LINES; l++) begin
            if (HAS_CASC != 0 && l == CASC_LINE) begin
                // cascade input arrives as a high-then-low pulse:
                // edge mode leaves it pending, level mode leaves it clear
                if (raw_i[l]) st_d.irr[l] = ~lvl_i[l];
            end else if (lvl_i[l]) begin
                st_d.irr[l] = raw_i[l];
            end else if (raw_i[l] && !st_q.last[l]) begin
                st_d.irr[l] = 1'b1;
            end
        end
        if (take_i) begin
            if (!lvl_i[take_line_i]) st_d.irr[take_line_i] = 1'b0;
            if (aeoi_i) begin
                if (rot_i) st_d.base = take_line_i + LW'(1);
            end else begin
                st_d.isr[take_line_i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    icv_prio #(.LINES(LINES)) u_prio (
        .req_i  (st_q.irr),
        .mask_i (mask_i),
        .isr_i  (st_q.isr),
        .base_i (st_q.base),
        .hit_o  (hit_o),
        .line_o (line_o)
    );

    AST_TAKE_IS_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |-> (hit_o && take_line_i == line_o)); // R3
    AST_TAKE_SETS_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && !aeoi_i) |=> st_q.isr[$past(take_line_i)]); // R4
    AST_EDGE_TAKE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && !lvl_i[take_line_i]) |=> !st_q.irr[$past(take_line_i)]); // R5
    AST_AEOI_KEEPS_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_i && aeoi_i) |=> (st_q.isr == $past(st_q.isr))); // R9
endmodule

// File: rtl/icv_ack_vec.sv
// Cascaded acknowledge handling, vector generation and interrupt output
module icv_ack_vec #(
    parameter int LINES     = icv_pkg::ICV_LINES,
    parameter int CASC_LINE = icv_pkg::ICV_CASC_LINE,
    parameter int VEC_W     = icv_pkg::ICV_VEC_W,
    localparam int LW     = $clog2(LINES),
    localparam int BASE_W = VEC_W - LW,
    localparam int ALL_W  = 2 * LINES
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [LINES-1:0]  slv_irq_i,
    input  logic [LINES-2:0]  mst_irq_i,
    input  logic [ALL_W-1:0]  lvl_mode_i,
    input  logic [ALL_W-1:0]  mask_i,
    input  logic [BASE_W-1:0] mst_base_i,
    input  logic [BASE_W-1:0] slv_base_i,
    input  logic [1:0]        aeoi_i,
    input  logic [1:0]        rot_aeoi_i,
    input  logic              inta_i,
    output logic [VEC_W-1:0]  vec_o,
    output logic              vec_vld_o,
    output logic              int_o
);
    import icv_pkg::*;

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic             vld;
        logic             irq;
    } out_state_t;

    out_state_t    out_d, out_q;
    logic [LINES-1:0] mst_raw;
    logic          m_hit, s_hit;
    logic [LW-1:0] m_line, s_line;
    logic          m_take, s_take;
    vec_src_t      src;
    logic [VEC_W-1:0] vec_sel;

    // master input vector with the slave's request spliced in at the cascade line
    for (genvar g = 0; g < LINES; g++) begin : g_mraw
        if (g < CASC_LINE) begin : g_lo
            assign mst_raw[g] = mst_irq_i[g];
        end else if (g == CASC_LINE) begin : g_casc
            assign mst_raw[g] = s_hit;
        end else begin : g_hi
            assign mst_raw[g] = mst_irq_i[g-1];
        end
    end

    icv_unit #(.LINES(LINES), .HAS_CASC(1), .CASC_LINE(CASC_LINE)) u_mst (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .raw_i       (mst_raw),
        .lvl_i       (lvl_mode_i[LINES-1:0]),
        .mask_i      (mask_i[LINES-1:0]),
        .aeoi_i      (aeoi_i[0]),
        .rot_i       (rot_aeoi_i[0]),
        .take_i      (m_take),
        .take_line_i (m_line),
        .hit_o       (m_hit),
        .line_o      (m_line)
    );

    icv_unit #(.LINES(LINES), .HAS_CASC(0), .CASC_LINE(CASC_LINE)) u_slv (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .raw_i       (slv_irq_i),
        .lvl_i       (lvl_mode_i[ALL_W-1:LINES]),
        .mask_i      (mask_i[ALL_W-1:LINES]),
        .aeoi_i      (aeoi_i[1]),
        .rot_i       (rot_aeoi_i[1]),
        .take_i      (s_take),
        .take_line_i (s_line),
        .hit_o       (s_hit),
        .line_o      (s_line)
    );

    always_comb begin
        src = SRC_MST_SPUR;
        if (m_hit) begin
            if (m_line == LW'(CASC_LINE)) src = s_hit ? SRC_SLV_LINE : SRC_SLV_SPUR;
            else                          src = SRC_MST_LINE;
        end
        case (src)
            SRC_MST_LINE: vec_sel = {mst_base_i, m_line};
            SRC_SLV_LINE: vec_sel = {slv_base_i, s_line};
            SRC_SLV_SPUR: vec_sel = {slv_base_i, {LW{1'b1}}};
            default:      vec_sel = {mst_base_i, {LW{1'b1}}};
        endcase
        m_take = inta_i && m_hit;
        s_take = inta_i && (src == SRC_SLV_LINE);

        out_d     = out_q;
        out_d.vld = inta_i;
        out_d.irq = !inta_i && m_hit;
        if (inta_i) out_d.vec = vec_sel;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign vec_o     = out_q.vec;
    assign vec_vld_o = out_q.vld;
    assign int_o     = out_q.irq;

    AST_VLD_FOLLOWS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inta_i |=> vec_vld_o); // R10
    AST_NO_VLD_WITHOUT_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !inta_i |=> !vec_vld_o); // R10
    AST_IRQ_LOW_ON_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_vld_o |-> !int_o); // R10
    AST_MST_SPUR_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inta_i && !m_hit) |=> (vec_o == {$past(mst_base_i), {LW{1'b1}}})); // R8
    AST_SLV_SPUR_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inta_i && m_hit && m_line == LW'(CASC_LINE) && !s_hit)
        |=> (vec_o == {$past(slv_base_i), {LW{1'b1}}})); // R7
endmodule

// File: tb/icv_ack_vec_bench.sv
module icv_ack_vec_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] slv_irq = '0;
    logic [6:0] mst_irq = '0;
    logic [15:0] lvl = '0, msk = '0;
    logic [4:0] mb = 5'h04, sb = 5'h05;
    logic [1:0] aeoi = '0, rot = '0;
    logic       inta = 1'b0;
    logic [7:0] vec;
    logic       vec_vld, int_o;

    int checks = 0, errors = 0;
    bit done = 0;

    // transaction-level expectation state
    bit [7:0] e_irr [2];
    bit [7:0] e_isr [2];
    bit [7:0] e_last [2];
    bit [2:0] e_base [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    icv_ack_vec u_icv_ack_vec (
        .clk_i(clk), .rst_ni(rst_n), .slv_irq_i(slv_irq), .mst_irq_i(mst_irq),
        .lvl_mode_i(lvl), .mask_i(msk), .mst_base_i(mb), .slv_base_i(sb),
        .aeoi_i(aeoi), .rot_aeoi_i(rot), .inta_i(inta),
        .vec_o(vec), .vec_vld_o(vec_vld), .int_o(int_o)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic void resolve(int c, output bit v, output int ln);
        int pr = 8, pi = 8;
        for (int p = 7; p >= 0; p--) begin
            int l = (p + e_base[c]) & 7;
            if (e_irr[c][l] && !msk[8*c + l]) pr = p;
            if (e_isr[c][l]) pi = p;
        end
        v  = (pr < 8) && (pr < pi);
        ln = (pr + e_base[c]) & 7;
    endfunction

    function automatic void latch(int c, bit [7:0] raw);
        for (int l = 0; l < 8; l++) begin
            if (c == 0 && l == 2) continue;
            if (lvl[8*c + l]) e_irr[c][l] = raw[l];
            else if (raw[l] && !e_last[c][l]) e_irr[c][l] = 1'b1;
        end
        e_last[c] = raw;
    endfunction

    function automatic void model_settle();
        bit v; int ln;
        latch(1, slv_irq);
        latch(0, {mst_irq[6:2], 1'b0, mst_irq[1:0]});
        resolve(1, v, ln);
        if (v) e_irr[0][2] = ~lvl[2];
    endfunction

    function automatic void take(int c, int l);
        if (!lvl[8*c + l]) e_irr[c][l] = 1'b0;
        if (aeoi[c]) begin
            if (rot[c]) e_base[c] = 3'((l + 1) & 7);
        end else e_isr[c][l] = 1'b1;
    endfunction

    task automatic settle_check(string tag);
        bit v; int ln;
        model_settle();
        repeat (5) @(negedge clk);
        resolve(0, v, ln);
        check({tag, " int_o"}, int_o, v);
        check("R10 idle vec_vld_o", vec_vld, 0);
    endtask

    task automatic apply(bit [7:0] s, bit [6:0] m, string tag);
        slv_irq = s;
        mst_irq = m;
        settle_check(tag);
    endtask

    task automatic ack(string tag);
        bit mv, sv; int ml, sl; int exp;
        resolve(0, mv, ml);
        resolve(1, sv, sl);
        if (!mv) exp = {mb, 3'd7};
        else if (ml == 2) exp = sv ? {sb, 3'(sl)} : {sb, 3'd7};
        else exp = {mb, 3'(ml)};
        if (mv) begin
            take(0, ml);
            if (ml == 2 && sv) take(1, sl);
        end
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
        check({tag, " vector"}, vec, exp);
        check("R10 vec_vld_o after ack", vec_vld, 1);
        check("R10 int_o low with vector", int_o, 0);
        settle_check(tag);
    endtask

    task automatic reset_dut(bit [15:0] l, bit [15:0] m, bit [1:0] a, bit [1:0] r);
        rst_n = 1'b0; inta = 1'b0; slv_irq = '0; mst_irq = '0;
        lvl = l; msk = m; aeoi = a; rot = r;
        for (int c = 0; c < 2; c++) begin
            e_irr[c] = '0; e_isr[c] = '0; e_last[c] = '0; e_base[c] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int junk;
        junk = $urandom(32'd4711);

        // R1 reset state
        reset_dut('0, '0, 2'b00, 2'b00);
        check("R1 int_o after reset", int_o, 0);
        check("R1 vec_vld_o after reset", vec_vld, 0);
        ack("R8 no request");
        apply(8'h00, 7'b0010000, "R2 edge line 5");
        ack("R4 line 5");
        apply(8'h00, 7'b0000000, "R2 edge not repending");
        apply(8'h00, 7'b0100000, "R4 line 6 blocked");
        apply(8'h00, 7'b0100100, "R3 line 3 above in-service");
        ack("R3 line 3");

        reset_dut('0, 16'h0008, 2'b00, 2'b00);
        apply(8'h00, 7'b0000100, "R3 masked line");

        reset_dut('0, '0, 2'b00, 2'b00);
        apply(8'h10, 7'b0000000, "R6 slave line 4");
        ack("R6 cascade vector");

        reset_dut(16'h0200, '0, 2'b00, 2'b00);
        apply(8'h02, 7'b0000000, "R7 slave level up");
        apply(8'h00, 7'b0000000, "R7 slave level down");
        ack("R7 spurious slave");

        reset_dut(16'h0040, '0, 2'b01, 2'b00);
        apply(8'h00, 7'b0100000, "R5 level line 6");
        ack("R5 level kept");
        ack("R9 no in-service");
        apply(8'h00, 7'b0001000, "R5 edge line 4");
        ack("R5 edge cleared");

        reset_dut('0, '0, 2'b01, 2'b01);
        apply(8'h00, 7'b0100010, "R9 lines 1 and 6");
        ack("R9 first");
        apply(8'h00, 7'b0100011, "R9 line 0 added");
        ack("R9 rotated order");
        ack("R9 last");

        reset_dut(16'h0004, '0, 2'b00, 2'b00);
        apply(8'h08, 7'b0000000, "R11 cascade level");

        // constrained random phase
        for (int it = 0; it < 160; it++) begin
            if (it % 20 == 0)
                reset_dut(16'($urandom) & 16'hFFFB, 16'($urandom & $urandom & $urandom),
                          2'($urandom), 2'($urandom));
            apply(8'($urandom), 7'($urandom), "R2 random");
            if ($urandom % 2 == 0) ack("R6 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule